// File: doc/BRIEF.md
# TDM Daisy-Chain Sample Shifter

This block turns one stereo sample pair into a serial TDM slot group and passes upstream traffic through behind it. It runs entirely on a shared bit clock. When a rising edge of the frame sync is seen, the left and right samples are packed into one 64-bit word and loaded in parallel into a shift register. The register then shifts one bit per bit clock. Its most significant bit leaves on the TDM output, and a bit from the TDM input enters at the bottom.

Several copies can be wired output-to-input on the same bit clock and frame sync. Together they act as one long shift path. With N copies, the last copy emits an N×64-bit frame: its own slot group first, then the group of the copy feeding it, and so on up the chain. The bit clock must run at 64·N times the frame rate. At a bit clock ceiling of about 25 MHz, eight copies fit at 48 kHz.

The serial stream cannot stall, so it has no valid/ready handshake. The consumer has to take one bit on every bit clock. The samples are taken only in the load cycle, so they must be held steady around the frame-sync edge.

Top module: `tdm_chain_shifter`

## Requirements
- R1: An active-low synchronous reset clears the shift register and the output flop. Until the first frame load, `tdm_out` then carries only zeros, or the bits that came in on `tdm_in`.
- R2: `fsync` is sampled on the rising bit-clock edge. A load happens only in the cycle where `fsync` is 1 and was 0 at the previous sample. If `fsync` stays high for further cycles, no further load happens.
- R3: A load writes the following layout:
  - bits 63:40 = left sample
  - bits 39:32 = zero
  - bits 31:8 = right sample
  - bits 7:0 = zero
- R4: Data leaves MSB first. The falling edge after the load edge presents bit 63, and each later falling edge presents the next lower bit.
- R5: In the load cycle, the load wins over the shift, and the `tdm_in` bit sampled at that edge is discarded.
- R6: In every non-load cycle, `tdm_in` is captured at the rising edge. With no load in between, that bit reaches `tdm_out` 64 bit clocks later.
- R7: `tdm_out` changes only on the falling bit-clock edge. It is steady across every rising edge.
- R8: When N copies are chained and the frame period is at least 64·N bit clocks, the last copy's output carries every copy's 64-bit group in order, nearest copy first. This happens within the first 64·N bit clocks after the load.
- R9: `left_smp` and `right_smp` are ignored in every cycle except the load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock shared by the whole chain |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; its rising edge triggers the parallel load |
| left_smp | input | 24 | Left-channel sample, taken at load |
| right_smp | input | 24 | Right-channel sample, taken at load |
| tdm_in | input | 1 | Serial data from the upstream copy |
| tdm_out | output | 1 | Serial data toward the next copy or the host |

## Verification
The bench chains three copies and compares every output bit against a queue of expected bits built from the sample values.

It goes after the following corner cases:
- A junk `1` is placed on `tdm_in` in the load cycle. A design that shifted instead of loading would show it as the last bit of the farthest group.
- `fsync` is held high for several cycles. A level-triggered design would reload and repeat the top bits.
- The samples are changed in the middle of a frame. A design that sampled them continuously would corrupt the stream.
- Frames longer than 192 clocks are run. The upstream bits must appear right after the three groups, which exposes an off-by-one in the chain delay.
- Reset is applied in the middle of a frame. A design that did not clear the register would leak stale data.

// File: rtl/tdm_shift_pkg.sv
`timescale 1ns/1ps
package tdm_shift_pkg;

  // Register operation selected each rising bit-clock edge
  typedef enum logic {
    OP_SHIFT = 1'b0,
    OP_LOAD  = 1'b1
  } shift_op_e;

  // Default geometry
  localparam int DEF_SAMPLE_W = 24;
  localparam int DEF_SLOT_W   = 32;
  localparam int DEF_NUM_CH   = 2;

endpackage

// File: rtl/tdm_fsync_detect.sv
`timescale 1ns/1ps
module tdm_fsync_detect
  import tdm_shift_pkg::*;
(
  input  logic      bclk,
  input  logic      rst_n,
  input  logic      fsync,
  output shift_op_e op
);

  logic fs_prev_q;

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b0;
    end else begin
      fs_prev_q <= fsync;
    end
  end

  // Rising edge of the sampled sync selects a load, otherwise shift
  always_comb begin
    if (fsync && !fs_prev_q) begin
      op = OP_LOAD;
    end else begin
      op = OP_SHIFT;
    end
  end

endmodule

// File: rtl/tdm_frame_pack.sv
`timescale 1ns/1ps
module tdm_frame_pack #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int NUM_CH   = 2,
  localparam int FRAME_W = SLOT_W * NUM_CH,
  localparam int PAD_W   = SLOT_W - SAMPLE_W
) (
  // Channel 0 lands in the most significant slot
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] samples,
  output logic [FRAME_W-1:0]              frame
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    localparam int TOP = FRAME_W - 1 - c * SLOT_W;
    if (PAD_W > 0) begin : g_pad
      assign frame[TOP -: SLOT_W] = {samples[c], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign frame[TOP -: SLOT_W] = samples[c];
    end
  end

endmodule

// File: rtl/tdm_shift_reg.sv
`timescale 1ns/1ps
module tdm_shift_reg
  import tdm_shift_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  shift_op_e        op,
  input  logic [WIDTH-1:0] load_val,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  q <= load_val;
        default:  q <= {q[WIDTH-2:0], ser_in};
      endcase
    end
  end

endmodule

// File: rtl/tdm_out_retime.sv
`timescale 1ns/1ps
module tdm_out_retime (
  input  logic bclk,
  input  logic rst_n,
  input  logic bit_in,
  output logic bit_out
);

  // Launch on the falling edge so the downstream rising edge sees a settled bit
  always_ff @(negedge bclk) begin
    if (!rst_n) begin
      bit_out <= 1'b0;
    end else begin
      bit_out <= bit_in;
    end
  end

endmodule

// File: rtl/tdm_chain_shifter.sv
`timescale 1ns/1ps
module tdm_chain_shifter
  import tdm_shift_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int SLOT_W   = DEF_SLOT_W
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                fsync,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  input  logic                tdm_in,
  output logic                tdm_out
);

  localparam int NUM_CH  = DEF_NUM_CH;
  localparam int FRAME_W = SLOT_W * NUM_CH;

  shift_op_e                       op;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_vec;
  logic [FRAME_W-1:0]              packed_frame;
  logic [FRAME_W-1:0]              shift_q;

  assign smp_vec[0] = left_smp;
  assign smp_vec[1] = right_smp;

  tdm_fsync_detect u_sync (
    .bclk  (bclk),
    .rst_n (rst_n),
    .fsync (fsync),
    .op    (op)
  );

  tdm_frame_pack #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W),
    .NUM_CH   (NUM_CH)
  ) u_pack (
    .samples (smp_vec),
    .frame   (packed_frame)
  );

  tdm_shift_reg #(
    .WIDTH (FRAME_W)
  ) u_sreg (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .op       (op),
    .load_val (packed_frame),
    .ser_in   (tdm_in),
    .q        (shift_q)
  );

  tdm_out_retime u_oret (
    .bclk    (bclk),
    .rst_n   (rst_n),
    .bit_in  (shift_q[FRAME_W-1]),
    .bit_out (tdm_out)
  );

endmodule

// File: rtl/tdm_chain_shifter_chk.sv
`timescale 1ns/1ps
module tdm_chain_shifter_chk #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int FRAME_W = 2 * SLOT_W,
  localparam int PAD_W   = SLOT_W - SAMPLE_W
) (
  input logic                bclk,
  input logic                rst_n,
  input logic                fsync,
  input logic [SAMPLE_W-1:0] left_smp,
  input logic [SAMPLE_W-1:0] right_smp,
  input logic                tdm_in,
  input logic                tdm_out,
  input logic [FRAME_W-1:0]  shreg
);

  logic fs_seen;
  always_ff @(posedge bclk) begin
    if (!rst_n) fs_seen <= 1'b0;
    else        fs_seen <= fsync;
  end

  logic [FRAME_W-1:0] exp_frame;
  assign exp_frame = {left_smp, {PAD_W{1'b0}}, right_smp, {PAD_W{1'b0}}};

  AST_LOAD_LAYOUT: assert property (@(posedge bclk) disable iff (!rst_n)
    (fsync && !fs_seen) |=> shreg == $past(exp_frame)); // R3

  AST_HELD_SYNC_SHIFTS: assert property (@(posedge bclk) disable iff (!rst_n)
    (fsync && fs_seen) |=> shreg[FRAME_W-1:1] == $past(shreg[FRAME_W-2:0])); // R2

  AST_SERIAL_ENTRY: assert property (@(posedge bclk) disable iff (!rst_n)
    !(fsync && !fs_seen) |=> shreg[0] == $past(tdm_in)); // R6

  AST_LOAD_DROPS_INPUT: assert property (@(posedge bclk) disable iff (!rst_n)
    (fsync && !fs_seen) |=> shreg[0] == 1'b0); // R5

  AST_OUT_TRACKS_MSB: assert property (@(posedge bclk) disable iff (!rst_n)
    tdm_out == shreg[FRAME_W-1]); // R4

endmodule

bind tdm_chain_shifter tdm_chain_shifter_chk #(
  .SAMPLE_W (SAMPLE_W),
  .SLOT_W   (SLOT_W)
) u_chk (
  .bclk      (bclk),
  .rst_n     (rst_n),
  .fsync     (fsync),
  .left_smp  (left_smp),
  .right_smp (right_smp),
  .tdm_in    (tdm_in),
  .tdm_out   (tdm_out),
  .shreg     (shift_q)
);

// File: tb/sim_tdm_chain_shifter.sv
`timescale 1ns/1ps
module sim_tdm_chain_shifter;

  localparam int NDEV = 3;
  localparam int FW   = 64;
  localparam int CHAIN = NDEV * FW;

  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic src_bit = 1'b0;
  logic [23:0] lsmp [NDEV];
  logic [23:0] rsmp [NDEV];
  logic link [NDEV+1];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit    q_v [$];
  string q_t [$];

  always #2.5 bclk = ~bclk;

  assign link[0] = src_bit;

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    tdm_chain_shifter u0 (
      .bclk      (bclk),
      .rst_n     (rst_n),
      .fsync     (fsync),
      .left_smp  (lsmp[d]),
      .right_smp (rsmp[d]),
      .tdm_in    (link[d]),
      .tdm_out   (link[d+1])
    );
  end

  logic last_out;
  assign last_out = link[NDEV];

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: one expected bit per falling edge
  initial begin
    forever begin
      @(negedge bclk);
      #1;
      if (rst_n && q_v.size() > 0) begin
        bit    e;
        string t;
        e = q_v.pop_front();
        t = q_t.pop_front();
        n_chk++;
        if (last_out !== e) begin
          n_bad++;
          $display("FAIL %s: tdm_out actual %b expected %b", t, last_out, e);
        end
      end
    end
  end

  // R7: output steady across each rising edge
  initial begin
    forever begin
      logic v;
      @(negedge bclk);
      #1 v = last_out;
      @(posedge bclk);
      #1;
      if (rst_n) begin
        n_chk++;
        if (last_out !== v) begin
          n_bad++;
          $display("FAIL R7: tdm_out actual %b expected %b", last_out, v);
        end
      end
    end
  end

  initial begin
    #900000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [63:0] frame_of(logic [23:0] l, logic [23:0] r);
    return {l, 8'h00, r, 8'h00}; // R3 layout
  endfunction

  function automatic logic [23:0] smp(int dev, int fr, int ch);
    return {4'(dev + 8), 4'(ch + 2), 16'(fr * 16'h1357 + 16'h0F0F)};
  endfunction

  function automatic bit tb_bit(int j);
    return bit'((j * 5 + 1) % 3 == 0);
  endfunction

  // Driver: one frame, hold = cycles fsync stays high, gap = frame period
  task automatic send_frame(int fr, int hold, int gap);
    logic [63:0] f;
    @(posedge bclk);
    #1;
    for (int d = 0; d < NDEV; d++) begin
      if (fr == 1) begin
        lsmp[d] = 24'hFFFFFF; rsmp[d] = 24'h800001;
      end else begin
        lsmp[d] = smp(d, fr, 0); rsmp[d] = smp(d, fr, 1);
      end
    end
    fsync   = 1'b1;
    src_bit = 1'b1; // R5: junk bit in the load cycle must be dropped
    @(posedge bclk); // load edge
    #0.5;
    for (int d = NDEV - 1; d >= 0; d--) begin
      f = frame_of(lsmp[d], rsmp[d]);
      for (int b = FW - 1; b >= 0; b--) begin
        q_v.push_back(f[b]);
        if (d == NDEV - 1)   q_t.push_back(b == FW - 1 ? "R4" : "R3");
        else if (d == 0 && b == 0) q_t.push_back("R5");
        else                 q_t.push_back("R8");
      end
    end
    for (int j = 1; j <= gap - CHAIN; j++) begin
      q_v.push_back(tb_bit(j));
      q_t.push_back("R6");
    end
    #0.5;
    for (int j = 1; j < gap; j++) begin
      fsync   = (j < hold);   // R2: held-high sync must not reload
      src_bit = tb_bit(j);
      if (j == 2) begin       // R9: samples ignored outside load
        for (int d = 0; d < NDEV; d++) begin
          lsmp[d] = 24'h5A5A5A ^ 24'(j + d);
          rsmp[d] = 24'hA5A5A5;
        end
      end
      @(posedge bclk);
      #1;
    end
  endtask

  initial begin
    for (int d = 0; d < NDEV; d++) begin
      lsmp[d] = '0; rsmp[d] = '0;
    end
    repeat (4) @(posedge bclk);
    #1 rst_n = 1'b1;
    // R1: zeros after reset before any load
    for (int i = 0; i < 100; i++) begin
      q_v.push_back(1'b0); q_t.push_back("R1");
    end
    repeat (110) @(posedge bclk);
    send_frame(0, 1, CHAIN);
    send_frame(1, 1, CHAIN);
    send_frame(2, 3, CHAIN);      // R2
    send_frame(3, 1, CHAIN + 20); // R6
    send_frame(4, 5, CHAIN + 8);
    // R1: reset in mid-frame clears stale data
    @(posedge bclk);
    #1;
    fsync = 1'b1;
    @(posedge bclk);
    #1 fsync = 1'b0;
    repeat (30) @(posedge bclk);
    #1 rst_n = 1'b0;
    src_bit = 1'b0;
    q_v.delete(); q_t.delete();
    repeat (3) @(posedge bclk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < CHAIN; i++) begin
      q_v.push_back(1'b0); q_t.push_back("R1");
    end
    repeat (CHAIN + 4) @(posedge bclk);
    send_frame(5, 1, CHAIN);      // R8 after reset
    repeat (4) @(posedge bclk);
    if (q_v.size() != 0) begin
      n_bad++;
      $display("FAIL R8: leftover actual %0d expected 0", q_v.size());
    end
    finish_run();
  end

endmodule